// File: doc/BRIEF.md
# Data-Rate Clock Enable Divider with External Realignment

This block sits in the clock tree of an interpolating converter datapath. It runs on the fastest internal clock, the converter update clock, and produces single-cycle clock enables at the input data rate, at twice that rate, and at four times that rate. The input capture registers, the 2x interpolation filter and the midscale insertion multiplexer each use one of these enables. All three come from one 2-bit phase counter, so they share its zero phase. The counter wraps every 2 update clocks when midscale insertion is off and every 4 when it is on.

With the frequency multiplier bypassed, the update clock comes from outside. An external realignment pulse then resets the phase counter, so that several devices fed from the same clock can line up their data-rate phase. The pulse is asynchronous: it passes through a two-flop synchroniser and only its rising edge acts. In bypass mode the multi-purpose status pin carries a data-rate square wave. With the multiplier active, the same pin shows a debounced lock indication taken from the asynchronous lock signal of the analog loop. The block also decodes the 2-bit prescaler select into a one-hot divide ratio.

Top module: `clk_div_sync`

## Requirements
- R1: While rst_n is low, the phase counter is held at zero: en_1x=1, en_2x=1, and lock_pin=0 when bypass=0.
- R2: With stuff_en=0, en_1x is high on every second update clock, en_2x is high on every clock, en_4x=0 and stuff_slot=0.
- R3: With stuff_en=1, en_1x is high on every fourth clock. en_2x is high on phases 0 and 2, which always include the en_1x cycle. en_4x=1 on every clock.
- R4: With stuff_en=1, stuff_slot is high on the odd phases (1 and 3), the slots where a midscale sample is inserted. It is never high together with en_2x.
- R5: With bypass=1, if resync_in rises before clock edge k, the phase counter is zero after edge k+2. en_1x is therefore high in the cycle after edge k+2, and the period continues from there.
- R6: With bypass=0, resync_in has no effect: the enables keep their free-running period.
- R7: With bypass=1, lock_pin carries the data-rate clock. It is high during the first half of each data period (phase 0 without stuffing; phases 0 and 1 with stuffing) and low for the rest.
- R8: With bypass=0, lock_pin rises after LOCK_CNT consecutive synchronised high samples of pll_lock_raw. With raw high from before edge k, it goes high after edge k+1+LOCK_CNT. A shorter high run never asserts it.
- R9: With bypass=0, a single low sample of pll_lock_raw clears the lock indication. With raw low from before edge j, lock_pin is low after edge j+2.
- R10: presc_ratio equals 1 shifted left by presc_sel (00→1, 01→2, 10→4, 11→8), whatever the value of stuff_en.
- R11: A resync_in held high realigns the counter once only. After that the period continues undisturbed until resync_in falls and rises again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Converter update clock (highest internal rate) |
| rst_n | input | 1 | Asynchronous active-low reset |
| bypass | input | 1 | 1 = frequency multiplier bypassed, external update clock |
| stuff_en | input | 1 | 1 = midscale insertion on, divide by 4; 0 = divide by 2 |
| resync_in | input | 1 | Asynchronous realignment pulse, acts only in bypass mode |
| pll_lock_raw | input | 1 | Asynchronous lock signal from the analog loop |
| presc_sel | input | SEL_W | Prescaler select code |
| en_1x | output | 1 | Data-rate enable (input capture) |
| en_2x | output | 1 | Twice-data-rate enable (interpolation filter) |
| en_4x | output | 1 | Four-times-data-rate enable (midscale insertion multiplexer) |
| stuff_slot | output | 1 | High on the update cycles that carry an inserted midscale sample |
| clk1x_out | output | 1 | Data-rate square wave |
| lock_pin | output | 1 | Data-rate clock in bypass mode, debounced lock otherwise |
| presc_ratio | output | 2**SEL_W | One-hot prescaler divide ratio |

## Verification
The assertions check on every cycle the relationships that must hold in any state. en_2x always accompanies en_1x. An insertion slot never coincides with en_2x. en_1x is never high on two consecutive cycles in multiplier mode, and it toggles each cycle when stuffing has been off for two cycles. In bypass mode the status pin is high whenever en_1x is. The prescaler ratio is always one-hot. Only the bench scenarios can show the exact timing: the edge on which a realignment takes effect, that a held realignment acts once only, and that realignment is ignored in multiplier mode. They also show the debounce count before lock and the two-edge latency of losing lock.

// File: rtl/clk_div_sync.sv
module clk_div_sync #(
  parameter int LOCK_CNT = 4,
  parameter int SEL_W    = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bypass,
  input  logic               stuff_en,
  input  logic               resync_in,
  input  logic               pll_lock_raw,
  input  logic [SEL_W-1:0]   presc_sel,
  output logic               en_1x,
  output logic               en_2x,
  output logic               en_4x,
  output logic               stuff_slot,
  output logic               clk1x_out,
  output logic               lock_pin,
  output logic [(1<<SEL_W)-1:0] presc_ratio
);
  localparam int RATIO_W = 1 << SEL_W;
  localparam int LCW     = $clog2(LOCK_CNT + 1);

  logic [1:0]     phase;
  logic [1:0]     rs_sync;
  logic           rs_prev;
  logic [1:0]     lk_sync;
  logic [LCW-1:0] lk_cnt;
  logic           lock_ok;
  logic           rs_rise;
  logic [1:0]     last_ph;

  assign rs_rise = rs_sync[1] & ~rs_prev;
  assign last_ph = stuff_en ? 2'd3 : 2'd1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs_sync <= '0;
      rs_prev <= 1'b0;
    end else begin
      rs_sync <= {rs_sync[0], resync_in};
      rs_prev <= rs_sync[1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      phase <= '0;
    else if (bypass && rs_rise)
      phase <= '0;
    else if (phase >= last_ph)
      phase <= '0;
    else
      phase <= phase + 2'd1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lk_sync <= '0;
      lk_cnt  <= '0;
    end else begin
      lk_sync <= {lk_sync[0], pll_lock_raw};
      if (!lk_sync[1])
        lk_cnt <= '0;
      else if (lk_cnt != LCW'(LOCK_CNT))
        lk_cnt <= lk_cnt + LCW'(1);
    end
  end

  assign lock_ok     = (lk_cnt == LCW'(LOCK_CNT));
  assign en_1x       = (phase == 2'd0);
  assign en_2x       = stuff_en ? ~phase[0] : 1'b1;
  assign en_4x       = stuff_en;
  assign stuff_slot  = stuff_en & phase[0];
  assign clk1x_out   = stuff_en ? ~phase[1] : ~phase[0];
  assign lock_pin    = bypass ? clk1x_out : lock_ok;
  assign presc_ratio = RATIO_W'(1) << presc_sel;
endmodule

// File: rtl/clk_div_sync_chk.sv
module clk_div_sync_chk #(
  parameter int SEL_W = 2
) (
  input logic clk,
  input logic rst_n,
  input logic bypass,
  input logic stuff_en,
  input logic en_1x,
  input logic en_2x,
  input logic stuff_slot,
  input logic lock_pin,
  input logic [(1<<SEL_W)-1:0] presc_ratio
);
  // R3
  en_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    en_1x |-> en_2x);

  // R4
  stuff_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stuff_slot |-> (stuff_en && !en_2x));

  // R2
  en_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en_1x && !bypass) |=> !en_1x);

  // R6
  free_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(rst_n, 2) && !$past(bypass) &&
     !$past(stuff_en) && !$past(stuff_en, 2)) |-> (en_1x != $past(en_1x)));

  // R7
  byp_clk_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bypass && en_1x) |-> lock_pin);

  // R10
  ratio_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(presc_ratio) == 1);
endmodule

bind clk_div_sync clk_div_sync_chk #(.SEL_W(SEL_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bypass(bypass), .stuff_en(stuff_en),
  .en_1x(en_1x), .en_2x(en_2x), .stuff_slot(stuff_slot),
  .lock_pin(lock_pin), .presc_ratio(presc_ratio)
);

// File: tb/tb_clk_div_sync.sv
module tb_clk_div_sync;
  localparam int LOCK_CNT = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bypass = 1'b0, stuff_en = 1'b0, resync_in = 1'b0, pll_lock_raw = 1'b0;
  logic [1:0] presc_sel = 2'd0;
  logic en_1x, en_2x, en_4x, stuff_slot, clk1x_out, lock_pin;
  logic [3:0] presc_ratio;
  int checks = 0, failures = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  clk_div_sync #(.LOCK_CNT(LOCK_CNT), .SEL_W(2)) dut (
    .clk(clk), .rst_n(rst_n), .bypass(bypass), .stuff_en(stuff_en),
    .resync_in(resync_in), .pll_lock_raw(pll_lock_raw), .presc_sel(presc_sel),
    .en_1x(en_1x), .en_2x(en_2x), .en_4x(en_4x), .stuff_slot(stuff_slot),
    .clk1x_out(clk1x_out), .lock_pin(lock_pin), .presc_ratio(presc_ratio));

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic sync1x();
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      if (en_1x) break;
    end
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    chk("R1 en_1x in reset", en_1x, 1);
    chk("R1 en_2x in reset", en_2x, 1);
    chk("R1 lock_pin in reset", lock_pin, 0);
    rst_n = 1'b1;
  endtask

  task automatic t_no_stuff();
    stuff_en = 1'b0; bypass = 1'b0;
    sync1x();
    chk("R2 sync found", en_1x, 1);
    for (int i = 1; i <= 8; i++) begin
      @(negedge clk);
      chk("R2 en_1x", en_1x, (i % 2 == 0));
      chk("R2 en_2x", en_2x, 1);
      chk("R2 en_4x", en_4x, 0);
      chk("R2 stuff_slot", stuff_slot, 0);
    end
  endtask

  task automatic t_stuff();
    stuff_en = 1'b1; bypass = 1'b0;
    sync1x();
    chk("R3 sync found", en_1x, 1);
    for (int i = 1; i <= 8; i++) begin
      @(negedge clk);
      chk("R3 en_1x", en_1x, (i % 4 == 0));
      chk("R3 en_2x", en_2x, (i % 2 == 0));
      chk("R3 en_4x", en_4x, 1);
      chk("R4 stuff_slot", stuff_slot, (i % 2 == 1));
    end
  endtask

  task automatic t_resync_bypass();
    bypass = 1'b1; stuff_en = 1'b1; resync_in = 1'b0;
    repeat (6) @(negedge clk);
    sync1x();
    resync_in = 1'b1;
    @(negedge clk); chk("R5 en_1x after k", en_1x, 0);
    @(negedge clk); chk("R5 en_1x after k+1", en_1x, 0);
    @(negedge clk); chk("R5 en_1x after k+2", en_1x, 1);
    for (int i = 1; i <= 8; i++) begin
      @(negedge clk);
      chk("R11 held resync period", en_1x, (i % 4 == 0));
    end
    resync_in = 1'b0;
  endtask

  task automatic t_resync_ignored();
    bypass = 1'b0; stuff_en = 1'b1; resync_in = 1'b0;
    repeat (6) @(negedge clk);
    sync1x();
    resync_in = 1'b1;
    repeat (3) @(negedge clk);
    chk("r6_ en_1x after k+2", en_1x, 0);
    @(negedge clk); chk("R6 en_1x after k+3", en_1x, 1);
    resync_in = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic t_lockpin_bypass();
    bypass = 1'b1; stuff_en = 1'b1;
    sync1x();
    chk("R7 stuff ph0", lock_pin, 1);
    @(negedge clk); chk("R7 stuff ph1", lock_pin, 1);
    @(negedge clk); chk("R7 stuff ph2", lock_pin, 0);
    @(negedge clk); chk("R7 stuff ph3", lock_pin, 0);
    stuff_en = 1'b0;
    sync1x();
    chk("R7 nostuff ph0", lock_pin, 1);
    @(negedge clk); chk("R7 nostuff ph1", lock_pin, 0);
  endtask

  task automatic t_lock();
    bypass = 1'b0; pll_lock_raw = 1'b0;
    repeat (4) @(negedge clk);
    pll_lock_raw = 1'b1;
    for (int i = 0; i < 3; i++) @(negedge clk);
    pll_lock_raw = 1'b0;
    @(negedge clk);
    pll_lock_raw = 1'b1;
    for (int i = 0; i <= 5; i++) begin
      @(negedge clk);
      chk("R8 debounce", lock_pin, (i == 5));
    end
    repeat (3) @(negedge clk);
    chk("R8 lock held", lock_pin, 1);
    pll_lock_raw = 1'b0;
    @(negedge clk); chk("R9 after j", lock_pin, 1);
    @(negedge clk); chk("R9 after j+1", lock_pin, 1);
    @(negedge clk); chk("R9 after j+2", lock_pin, 0);
    pll_lock_raw = 1'b1;
    @(negedge clk);
    pll_lock_raw = 1'b0;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      chk("R8 one-sample pulse", lock_pin, 0);
    end
  endtask

  task automatic t_presc();
    for (int s = 0; s < 2; s++) begin
      for (int d = 0; d < 4; d++) begin
        stuff_en = s[0]; presc_sel = d[1:0];
        #1;
        chk("R10 ratio", int'(presc_ratio), 1 << d);
      end
    end
    stuff_en = 1'b0;
  endtask

  initial begin
    t_reset();
    t_no_stuff();
    t_stuff();
    t_resync_bypass();
    t_resync_ignored();
    t_lockpin_bypass();
    t_lock();
    t_presc();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; failures++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule